// File: doc/BRIEF.md
# Chroma-Key Pixel Replacement Unit

This block is a streaming stage in the graphics overlay path. Each 16-bit RGB565 overlay pixel is compared with a programmable key colour. When every channel matches and keying is switched on, the pixel is replaced by a programmable substitute colour and given a programmable alpha. Otherwise the pixel keeps its colour and is fully opaque. A final stage mixes the result with the pixel from the lower video layer. Characters or a cursor drawn on the overlay can then sit over live video, with the keyed background showing the layer below.

Software writes its settings into staging registers through a small word-wide register port. The settings reach the pixel path only when software has raised an update-request flag and the vertical sync marker of the stream is seen. The flag drops by itself once the copy is made, so a frame is never drawn with half-applied settings. A mode input narrows the comparison to the low four bits of each key channel when the display bus carries 4-bit channels.

Top module: `ckey_overlay_unit`

## Requirements
- R1: After reset all staging and active settings are zero, keying is off, the update-request flag reads 0 and `out_valid`, `out_hsync`, `out_vsync` are 0.
- R2: Register 0 (key) holds the enable in bit 16, the red key in bits 15:11, the green key in bits 10:5 and the blue key in bits 4:0. Bits 31:17 read as 0. Address 3 reads as 0.
- R3: A pixel is keyed only when the enable is 1 and its red, green and blue fields all equal the key fields. Any other pixel keeps its colour with alpha 255.
- R4: Register 1 (substitute) holds the replacement RGB565 colour in bits 15:0 and the alpha in bits 23:16. Bits 31:24 read as 0. A keyed pixel takes both values.
- R5: Writes to registers 0 and 1 change only the staging copy, which reads back at once. The pixel path keeps using the active copy until a commit.
- R6: Writing 1 to bit 0 of register 2 sets the update-request flag, which reads back in bit 0. On any clock where the flag is set and `in_vsync` is 1, the staging copy moves to the active copy and the flag clears.
- R7: Every input beat appears at the outputs exactly 2 clocks later. `out_valid`, `out_hsync` and `out_vsync` are the inputs delayed by 2.
- R8: With `mode_rgb444` at 1, only bits 3:0 of each channel field (red 14:11, green 8:5, blue 3:0) take part in the comparison. The key enable still gates matching.
- R9: Each output channel is (a*u + (255-a)*l)/255, truncated, at its native width, where u is the keyed or passed pixel, l is `in_lower` and a is the alpha.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 key, 1 substitute, 2 update request) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| mode_rgb444 | input | 1 | 1 selects 4-bit channel comparison |
| in_valid | input | 1 | Input pixel valid |
| in_hsync | input | 1 | Horizontal sync marker |
| in_vsync | input | 1 | Vertical sync marker, also the commit point |
| in_pix | input | 16 | Overlay pixel, RGB565 |
| in_lower | input | 16 | Lower-layer pixel, RGB565 |
| out_valid | output | 1 | Output pixel valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_pix | output | 16 | Blended pixel, RGB565 |

## Verification
Three kinds of pixel are sent. Exact key pixels test that the match fires. Pixels one channel away from the key show that no single channel can trigger a match on its own. Random pixels with random lower-layer values exercise the blend arithmetic at many alpha and channel values. Key pixels sent after a staged write but before the vsync commit tell the staging copy from the active one. The same key pixels after disabling tell the enable apart from the compare. A pixel that differs from the key only in the top bit of a channel tells the 4-bit comparison mode from the full one.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

   typedef enum logic [1:0] {
      CK_REG_KEY    = 2'd0,
      CK_REG_SUBST  = 2'd1,
      CK_REG_UPDATE = 2'd2,
      CK_REG_SPARE  = 2'd3
   } ck_reg_e;

   // channel 0 = blue (lowest), 1 = green, 2 = red
   function automatic int ch_width(input int ch, input int bw, input int gw, input int rw);
      return (ch == 0) ? bw : ((ch == 1) ? gw : rw);
   endfunction

   function automatic int ch_low(input int ch, input int bw, input int gw);
      return (ch == 0) ? 0 : ((ch == 1) ? bw : bw + gw);
   endfunction

endpackage

// File: rtl/ckey_regs.sv
module ckey_regs
   import ckey_pkg::*;
#(
   parameter int PIX_W   = 16,
   parameter int ALPHA_W = 8,
   parameter int DATA_W  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [1:0]                 cfg_addr,
   input  logic [DATA_W-1:0]          cfg_wdata,
   output logic [DATA_W-1:0]          cfg_rdata,
   input  logic                       vsync_in,
   output logic                       act_en,
   output logic [PIX_W-1:0]           act_key,
   output logic [PIX_W+ALPHA_W-1:0]   act_subst,
   output logic                       pending
);
   localparam int KEY_BITS = PIX_W + 1;
   localparam int SUB_BITS = PIX_W + ALPHA_W;

   if (DATA_W < SUB_BITS) begin : g_bad_data_w
      $error("ckey_regs: DATA_W too narrow for substitute register");
   end

   logic [KEY_BITS-1:0] stg_key;
   logic [SUB_BITS-1:0] stg_sub;
   logic [KEY_BITS-1:0] act_key_q;
   logic [SUB_BITS-1:0] act_sub_q;
   logic                pend_q;
   logic                commit;
   logic                req_set;
   logic                unused_wdata;

   assign commit  = pend_q & vsync_in;
   assign req_set = cfg_we && (ck_reg_e'(cfg_addr) == CK_REG_UPDATE) && cfg_wdata[0];
   assign unused_wdata = ^cfg_wdata[DATA_W-1:SUB_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_key   <= '0;
         stg_sub   <= '0;
         act_key_q <= '0;
         act_sub_q <= '0;
         pend_q    <= 1'b0;
      end else begin
         if (commit) begin
            act_key_q <= stg_key;
            act_sub_q <= stg_sub;
         end
         if (cfg_we) begin
            case (ck_reg_e'(cfg_addr))
               CK_REG_KEY:   stg_key <= cfg_wdata[KEY_BITS-1:0];
               CK_REG_SUBST: stg_sub <= cfg_wdata[SUB_BITS-1:0];
               default: ;
            endcase
         end
         if (req_set)
            pend_q <= 1'b1;
         else if (commit)
            pend_q <= 1'b0;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (ck_reg_e'(cfg_addr))
         CK_REG_KEY:    cfg_rdata[KEY_BITS-1:0] = stg_key;
         CK_REG_SUBST:  cfg_rdata[SUB_BITS-1:0] = stg_sub;
         CK_REG_UPDATE: cfg_rdata[0]            = pend_q;
         default:       cfg_rdata               = '0;
      endcase
   end

   assign act_en    = act_key_q[PIX_W];
   assign act_key   = act_key_q[PIX_W-1:0];
   assign act_subst = act_sub_q;
   assign pending   = pend_q;

   // R5: active copy changes only on a commit clock
   a_r5_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable({act_key_q, act_sub_q}));

   // R6: flag drops after commit unless re-requested
   a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !req_set) |=> !pending);

   // R2: reserved bits of the key register read zero
   a_r2_key_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_reg_e'(cfg_addr) == CK_REG_KEY) |-> (cfg_rdata[DATA_W-1:KEY_BITS] == '0));

endmodule

// File: rtl/ckey_match.sv
module ckey_match
   import ckey_pkg::*;
#(
   parameter int R_W      = 5,
   parameter int G_W      = 6,
   parameter int B_W      = 5,
   parameter int ALPHA_W  = 8,
   parameter int NARROW_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       narrow,
   input  logic                       act_en,
   input  logic [R_W+G_W+B_W-1:0]     act_key,
   input  logic [R_W+G_W+B_W-1:0]     act_color,
   input  logic [ALPHA_W-1:0]         act_alpha,
   input  logic                       in_valid,
   input  logic                       in_hsync,
   input  logic                       in_vsync,
   input  logic [R_W+G_W+B_W-1:0]     in_pix,
   input  logic [R_W+G_W+B_W-1:0]     in_lower,
   output logic                       s_valid,
   output logic                       s_hsync,
   output logic                       s_vsync,
   output logic [R_W+G_W+B_W-1:0]     s_upper,
   output logic [ALPHA_W-1:0]         s_alpha,
   output logic [R_W+G_W+B_W-1:0]     s_lower
);
   localparam int PIX_W = R_W + G_W + B_W;

   logic [2:0] hit;
   logic       match;

   for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      localparam int W  = ch_width(ch, B_W, G_W, R_W);
      localparam int LO = ch_low(ch, B_W, G_W);
      localparam logic [W-1:0] NMASK = W'((2 ** NARROW_W) - 1);
      if (NARROW_W > W) begin : g_bad_narrow
         $error("ckey_match: NARROW_W exceeds a channel width");
      end
      logic [W-1:0] mask;
      logic [W-1:0] diff;
      assign mask     = narrow ? NMASK : {W{1'b1}};
      assign diff     = in_pix[LO +: W] ^ act_key[LO +: W];
      assign hit[ch]  = ((diff & mask) == '0);
   end

   assign match = act_en & (&hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= 1'b0;
         s_hsync <= 1'b0;
         s_vsync <= 1'b0;
         s_upper <= '0;
         s_alpha <= '0;
         s_lower <= '0;
      end else begin
         s_valid <= in_valid;
         s_hsync <= in_hsync;
         s_vsync <= in_vsync;
         s_upper <= match ? act_color : in_pix;
         s_alpha <= match ? act_alpha : {ALPHA_W{1'b1}};
         s_lower <= in_lower;
      end
   end

   // R3: with keying off every pixel passes opaque and unchanged
   a_r3_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !act_en) |=> (s_alpha == {ALPHA_W{1'b1}} && s_upper == $past(in_pix)));

   // R3: a pixel differing in the full-width compare is never keyed
   a_r3_mismatch_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !narrow && in_pix != act_key) |=> (s_upper == $past(in_pix)));

   initial begin
      assert (PIX_W > 0) else $error("ckey_match: empty pixel");
   end

endmodule

// File: rtl/ckey_blend_chan.sv
module ckey_blend_chan #(
   parameter int W       = 5,
   parameter int ALPHA_W = 8
) (
   input  logic [ALPHA_W-1:0] alpha,
   input  logic [W-1:0]       upper,
   input  logic [W-1:0]       lower,
   output logic [W-1:0]       mix
);
   localparam int SUM_W = W + ALPHA_W + 1;
   localparam logic [SUM_W-1:0] FULL = SUM_W'((2 ** ALPHA_W) - 1);

   logic [SUM_W-1:0] acc;
   logic [SUM_W-1:0] quo;
   logic [SUM_W-W-1:0] unused_quo;

   always_comb begin
      acc = SUM_W'(alpha) * SUM_W'(upper) + (FULL - SUM_W'(alpha)) * SUM_W'(lower);
      quo = acc / FULL;
   end

   assign mix        = quo[W-1:0];
   assign unused_quo = quo[SUM_W-1:W];

endmodule

// File: rtl/ckey_blend.sv
module ckey_blend
   import ckey_pkg::*;
#(
   parameter int R_W     = 5,
   parameter int G_W     = 6,
   parameter int B_W     = 5,
   parameter int ALPHA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     s_valid,
   input  logic                     s_hsync,
   input  logic                     s_vsync,
   input  logic [R_W+G_W+B_W-1:0]   s_upper,
   input  logic [ALPHA_W-1:0]       s_alpha,
   input  logic [R_W+G_W+B_W-1:0]   s_lower,
   output logic                     out_valid,
   output logic                     out_hsync,
   output logic                     out_vsync,
   output logic [R_W+G_W+B_W-1:0]   out_pix
);
   localparam int PIX_W = R_W + G_W + B_W;

   logic [PIX_W-1:0] mixed;

   for (genvar ch = 0; ch < 3; ch++) begin : g_mix
      localparam int W  = ch_width(ch, B_W, G_W, R_W);
      localparam int LO = ch_low(ch, B_W, G_W);
      ckey_blend_chan #(.W(W), .ALPHA_W(ALPHA_W)) i_chan (
         .alpha (s_alpha),
         .upper (s_upper[LO +: W]),
         .lower (s_lower[LO +: W]),
         .mix   (mixed[LO +: W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hsync <= 1'b0;
         out_vsync <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= s_valid;
         out_hsync <= s_hsync;
         out_vsync <= s_vsync;
         out_pix   <= mixed;
      end
   end

   // R9: full alpha shows the upper pixel unchanged
   a_r9_opaque_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_alpha == {ALPHA_W{1'b1}}) |=> (out_pix == $past(s_upper)));

   // R9: zero alpha shows the lower pixel unchanged
   a_r9_clear_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_alpha == '0) |=> (out_pix == $past(s_lower)));

endmodule

// File: rtl/ckey_overlay_unit.sv
module ckey_overlay_unit
   import ckey_pkg::*;
#(
   parameter int R_W      = 5,
   parameter int G_W      = 6,
   parameter int B_W      = 5,
   parameter int ALPHA_W  = 8,
   parameter int NARROW_W = 4,
   parameter int DATA_W   = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [1:0]             cfg_addr,
   input  logic [DATA_W-1:0]      cfg_wdata,
   output logic [DATA_W-1:0]      cfg_rdata,
   input  logic                   mode_rgb444,
   input  logic                   in_valid,
   input  logic                   in_hsync,
   input  logic                   in_vsync,
   input  logic [R_W+G_W+B_W-1:0] in_pix,
   input  logic [R_W+G_W+B_W-1:0] in_lower,
   output logic                   out_valid,
   output logic                   out_hsync,
   output logic                   out_vsync,
   output logic [R_W+G_W+B_W-1:0] out_pix
);
   localparam int PIX_W = R_W + G_W + B_W;
   localparam int SUB_W = PIX_W + ALPHA_W;

   if (R_W < 1 || G_W < 1 || B_W < 1) begin : g_bad_chan
      $error("ckey_overlay_unit: channel widths must be positive");
   end
   if (ALPHA_W < 1) begin : g_bad_alpha
      $error("ckey_overlay_unit: ALPHA_W must be positive");
   end

   logic               act_en;
   logic [PIX_W-1:0]   act_key;
   logic [SUB_W-1:0]   act_subst;
   logic               pending;
   logic               s_valid, s_hsync, s_vsync;
   logic [PIX_W-1:0]   s_upper, s_lower;
   logic [ALPHA_W-1:0] s_alpha;
   logic               unused_pending;

   assign unused_pending = pending;

   ckey_regs #(.PIX_W(PIX_W), .ALPHA_W(ALPHA_W), .DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .vsync_in  (in_vsync),
      .act_en    (act_en),
      .act_key   (act_key),
      .act_subst (act_subst),
      .pending   (pending)
   );

   ckey_match #(.R_W(R_W), .G_W(G_W), .B_W(B_W), .ALPHA_W(ALPHA_W), .NARROW_W(NARROW_W)) i_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .narrow    (mode_rgb444),
      .act_en    (act_en),
      .act_key   (act_key),
      .act_color (act_subst[PIX_W-1:0]),
      .act_alpha (act_subst[SUB_W-1:PIX_W]),
      .in_valid  (in_valid),
      .in_hsync  (in_hsync),
      .in_vsync  (in_vsync),
      .in_pix    (in_pix),
      .in_lower  (in_lower),
      .s_valid   (s_valid),
      .s_hsync   (s_hsync),
      .s_vsync   (s_vsync),
      .s_upper   (s_upper),
      .s_alpha   (s_alpha),
      .s_lower   (s_lower)
   );

   ckey_blend #(.R_W(R_W), .G_W(G_W), .B_W(B_W), .ALPHA_W(ALPHA_W)) i_blend (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_valid   (s_valid),
      .s_hsync   (s_hsync),
      .s_vsync   (s_vsync),
      .s_upper   (s_upper),
      .s_alpha   (s_alpha),
      .s_lower   (s_lower),
      .out_valid (out_valid),
      .out_hsync (out_hsync),
      .out_vsync (out_vsync),
      .out_pix   (out_pix)
   );

   // R7: valid and sync markers arrive two clocks later
   a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);
   a_r7_vsync_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_vsync |-> ##2 out_vsync);
   a_r7_hsync_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_hsync |-> ##2 out_hsync);

endmodule

// File: tb/test_ckey_overlay_unit.sv
`timescale 1ns/1ps
module test_ckey_overlay_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mode_rgb444 = 1'b0;
   logic        in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
   logic [15:0] in_pix = '0, in_lower = '0;
   logic        out_valid, out_hsync, out_vsync;
   logic [15:0] out_pix;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string phase = "R1 reset";

   always #2.5 clk = ~clk;

   ckey_overlay_unit i_ckey_overlay_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_rgb444(mode_rgb444),
      .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
      .in_pix(in_pix), .in_lower(in_lower), .out_valid(out_valid),
      .out_hsync(out_hsync), .out_vsync(out_vsync), .out_pix(out_pix));

   // ---------------- behavioural reference ----------------
   logic [16:0] g_key = '0, a_key = '0;
   logic [23:0] g_sub = '0, a_sub = '0;
   bit          pend = 0;
   bit          q_v[$], q_h[$], q_s[$];
   logic [15:0] q_p[$];
   bit          e_v = 0, e_h = 0, e_s = 0;
   logic [15:0] e_p = '0;

   function automatic bit key_hit(logic [15:0] p, logic [16:0] k, bit nar);
      int m_r, m_g, m_b;
      m_r = nar ? 15 : 31; m_g = nar ? 15 : 63; m_b = nar ? 15 : 31;
      return k[16] && ((int'(p[15:11]) & m_r) == (int'(k[15:11]) & m_r))
                   && ((int'(p[10:5])  & m_g) == (int'(k[10:5])  & m_g))
                   && ((int'(p[4:0])   & m_b) == (int'(k[4:0])   & m_b));
   endfunction

   function automatic logic [15:0] mix(logic [15:0] u, logic [15:0] l, int a);
      int r, g, b;
      r = (a * int'(u[15:11]) + (255 - a) * int'(l[15:11])) / 255;
      g = (a * int'(u[10:5])  + (255 - a) * int'(l[10:5]))  / 255;
      b = (a * int'(u[4:0])   + (255 - a) * int'(l[4:0]))   / 255;
      return {r[4:0], g[5:0], b[4:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         g_key = '0; a_key = '0; g_sub = '0; a_sub = '0; pend = 0;
         q_v.delete(); q_h.delete(); q_s.delete(); q_p.delete();
         q_v.push_back(0); q_h.push_back(0); q_s.push_back(0); q_p.push_back('0);
         e_v = 0; e_h = 0; e_s = 0; e_p = '0;
      end else begin
         bit hit;
         hit = key_hit(in_pix, a_key, mode_rgb444);
         q_v.push_back(in_valid); q_h.push_back(in_hsync); q_s.push_back(in_vsync);
         q_p.push_back(hit ? mix(a_sub[15:0], in_lower, int'(a_sub[23:16]))
                           : mix(in_pix, in_lower, 255));
         e_v = q_v.pop_front(); e_h = q_h.pop_front();
         e_s = q_s.pop_front(); e_p = q_p.pop_front();
         if (pend && in_vsync) begin a_key = g_key; a_sub = g_sub; pend = 0; end
         if (cfg_we) begin
            if (cfg_addr == 2'd0) g_key = cfg_wdata[16:0];
            if (cfg_addr == 2'd1) g_sub = cfg_wdata[23:0];
            if (cfg_addr == 2'd2 && cfg_wdata[0]) pend = 1;
         end
      end
   end

   function automatic logic [31:0] exp_rd(logic [1:0] ad);
      case (ad)
         2'd0: return {15'd0, g_key};
         2'd1: return {8'd0, g_sub};
         2'd2: return {31'd0, pend};
         default: return '0;
      endcase
   endfunction

   // compare every clock, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         checks++;
         if ({out_valid, out_hsync, out_vsync} != {e_v, e_h, e_s}) begin
            errors++;
            $display("FAIL %s R7 markers act %b exp %b", phase,
                     {out_valid, out_hsync, out_vsync}, {e_v, e_h, e_s});
         end
         if (e_v) begin
            checks++;
            if (out_pix !== e_p) begin
               errors++;
               $display("FAIL %s R9 out_pix act %h exp %h", phase, out_pix, e_p);
            end
         end
         checks++;
         if (cfg_rdata !== exp_rd(cfg_addr)) begin
            errors++;
            $display("FAIL %s R6 cfg_rdata act %h exp %h", phase, cfg_rdata, exp_rd(cfg_addr));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] ad, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(logic [1:0] ad, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = ad;
      #0.5 d = cfg_rdata;
   endtask

   task automatic beat(logic [15:0] p, logic [15:0] l, bit v, bit hs, bit vs);
      @(negedge clk);
      in_pix = p; in_lower = l; in_valid = v; in_hsync = hs; in_vsync = vs;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) beat('0, '0, 0, 0, 0);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   localparam logic [15:0] KEY = 16'hF81F;

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      chk("R1 out_valid after reset", {31'd0, out_valid}, 0);
      rd(2'd0, d); chk("R1 key register after reset", d, 0);
      rd(2'd2, d); chk("R1 update flag after reset", d, 0);
      phase = "R1 keying off after reset";
      beat(16'h0000, 16'h1234, 1, 0, 0);
      idle(3);

      phase = "R2 R4 register layout";
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 key reserved bits", d, 32'h0001_FFFF);
      wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R4 substitute reserved bits", d, 32'h00FF_FFFF);
      rd(2'd3, d); chk("R2 spare address", d, 0);

      phase = "R5 staged only";
      wr(2'd0, {15'd0, 1'b1, KEY});
      wr(2'd1, {8'd0, 8'h40, 16'h07E0});
      wr(2'd2, 32'd1);
      rd(2'd2, d); chk("R6 flag set", d, 1);
      for (int i = 0; i < 4; i++) beat(KEY, 16'(i * 16'h1111), 1, i == 2, 0);
      idle(2);

      phase = "R6 commit at vsync";
      beat('0, '0, 0, 0, 1);
      idle(1);
      rd(2'd2, d); chk("R6 flag clears after commit", d, 0);

      phase = "R3 R4 keyed stream";
      beat(KEY, 16'h0000, 1, 1, 0);
      beat(KEY, 16'hFFFF, 1, 0, 0);
      beat(KEY ^ 16'h0800, 16'h5555, 1, 0, 0);
      beat(KEY ^ 16'h0020, 16'h5555, 1, 0, 0);
      beat(KEY ^ 16'h0001, 16'h5555, 1, 0, 0);
      beat(KEY, 16'hA5A5, 0, 0, 0);
      idle(3);

      phase = "R3 disabled";
      wr(2'd0, {16'd0, KEY});
      wr(2'd2, 32'd1);
      beat(KEY, 16'h3333, 1, 0, 0);
      beat('0, '0, 0, 0, 1);
      beat(KEY, 16'h3333, 1, 0, 0);
      beat(KEY, 16'hCCCC, 1, 0, 0);
      idle(3);

      phase = "R8 narrow compare";
      wr(2'd0, {15'd0, 1'b1, KEY});
      wr(2'd1, {8'd0, 8'h00, 16'h001F});
      wr(2'd2, 32'd1);
      beat('0, '0, 0, 0, 1);
      mode_rgb444 = 1'b1;
      beat(16'h7A0F, 16'h1357, 1, 0, 0);
      beat(16'h7A0F, 16'h2468, 1, 0, 0);
      beat(16'h7A2F, 16'h2468, 1, 0, 0);
      mode_rgb444 = 1'b0;
      beat(16'h7A0F, 16'h1357, 1, 0, 0);
      idle(3);

      phase = "R9 random blend";
      wr(2'd1, {8'd0, 8'h9C, 16'h4A69});
      wr(2'd2, 32'd1);
      beat('0, '0, 0, 0, 1);
      for (int i = 0; i < 600; i++) begin
         logic [15:0] p;
         p = ($urandom % 3 == 0) ? KEY : 16'($urandom);
         if (i == 300) begin
            wr(2'd1, {8'd0, 8'($urandom), 16'($urandom)});
            wr(2'd2, 32'd1);
         end
         beat(p, 16'($urandom), ($urandom % 5) != 0, (i % 64) == 63, (i % 200) == 199);
      end
      idle(4);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

endmodule